// File: doc/BRIEF.md
# Strobed PCM Serial Port

This block moves one 8-bit companded voice sample per frame between a local codec core and a line-side device over a strobed serial link. The line side supplies a bit clock and an active-high frame strobe that repeats at 8 kHz. While the strobe is high, the port drives one byte out and captures one byte in over a single 8-bit timeslot. Outgoing data changes on rising bit-clock edges. Incoming data is sampled on falling bit-clock edges.

The outgoing byte is taken from the encoder side when the strobe rises. The incoming byte goes to the decoder side together with a one-cycle valid pulse. Two independent mute inputs, one per direction, replace the data with the quiet code of the selected companding law. The bit clock, the strobe and the serial input are oversampled by a faster system clock. Each passes through a two-stage synchronizer, and an edge detector follows.

Top module: `pcm_strobe_port`

## Requirements
- R1: While rst_n is low and after it is released, dout_oe is 0, rx_valid is 0 and rx_byte is 0x00.
- R2: dout_oe goes to 1 at the first bit-clock rising edge after a strobe rise. It returns to 0 at the eighth falling edge or when the strobe falls, whichever comes first. It is never 1 while the strobe is low.
- R3: The byte on tx_byte when the strobe rises is sent MSB first, one bit per bit-clock rising edge. A later change of tx_byte within the slot has no effect on the byte being sent.
- R4: din is sampled MSB first on each bit-clock falling edge within the slot. After the eighth falling edge, rx_byte holds the assembled byte and rx_valid is high for exactly one clk cycle.
- R5: If tx_mute is 1 when the strobe rises, the quiet code is sent instead of tx_byte.
- R6: If rx_mute is 1 when the strobe rises, rx_byte carries the quiet code at the valid pulse, whatever arrived on din.
- R7: The quiet code is 0x55 when law_a is 1 (A-law) and 0x7F when law_a is 0 (µ-law).
- R8: tx_mute, rx_mute and law_a are sampled only at the strobe rise. Changing them inside the slot alters neither byte.
- R9: Bit-clock cycles after the eighth within the same strobe are ignored: there is no output drive and no further valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial signals |
| rst_n | input | 1 | Active-low reset to the idle state |
| bclk | input | 1 | Serial bit clock from the line side |
| strb | input | 1 | Active-high frame strobe marking the timeslot |
| din | input | 1 | Serial receive data |
| tx_byte | input | 8 | Encoder-side sample to transmit |
| tx_mute | input | 1 | Send the quiet code instead of tx_byte |
| rx_mute | input | 1 | Deliver the quiet code instead of the received byte |
| law_a | input | 1 | 1 selects A-law quiet code, 0 selects µ-law |
| dout | output | 1 | Serial transmit data |
| dout_oe | output | 1 | Drive enable for dout; 0 means high impedance |
| rx_byte | output | 8 | Decoder-side received sample |
| rx_valid | output | 1 | One-cycle pulse when rx_byte is updated |

## Verification
Every edge on bclk or strb takes effect on the third rising clk edge after it. Two edges go through the synchronizer and one registers the result. So dout, dout_oe and rx_valid move three clk cycles after the serial edge that causes them. The bench drives the serial inputs on falling clk edges and holds each bit-clock phase for eight clk cycles. It samples dout and dout_oe six cycles into the high phase, well after the three-cycle delay and before the next edge. Valid pulses are counted by a monitor on every clk edge, so a missing pulse or a second pulse in the same slot is seen no matter when it lands.

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk,
  input  logic       strb,
  input  logic       din,
  input  logic [7:0] tx_byte,
  input  logic       tx_mute,
  input  logic       rx_mute,
  input  logic       law_a,
  output logic       dout,
  output logic       dout_oe,
  output logic [7:0] rx_byte,
  output logic       rx_valid
);
  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);
  localparam int PW   = SYNC + 1;
  localparam logic [7:0] Q_ALAW = 8'h55;
  localparam logic [7:0] Q_MULAW = 8'h7F;

  logic [PW-1:0] bclk_p, strb_p, din_p;
  logic [BITS-1:0] tx_sh, rx_sh;
  logic [CW-1:0] txcnt, rxcnt;
  logic rx_mute_q, law_q;

  wire b_rise  = bclk_p[SYNC-1] & ~bclk_p[SYNC];
  wire b_fall  = ~bclk_p[SYNC-1] & bclk_p[SYNC];
  wire s_on    = strb_p[SYNC-1];
  wire s_rise  = strb_p[SYNC-1] & ~strb_p[SYNC];
  wire s_fall  = ~strb_p[SYNC-1] & strb_p[SYNC];
  wire din_s   = din_p[SYNC-1];
  wire [7:0] quiet_now = law_a ? Q_ALAW : Q_MULAW;
  wire [7:0] quiet_q   = law_q ? Q_ALAW : Q_MULAW;
  wire tx_step = s_on & b_rise & (txcnt < CW'(BITS));
  wire rx_step = s_on & b_fall & (rxcnt < txcnt);
  wire rx_last = rx_step & (rxcnt == CW'(BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_p <= '0; strb_p <= '0; din_p <= '0;
      tx_sh <= '0; rx_sh <= '0; txcnt <= '0; rxcnt <= '0;
      rx_mute_q <= 1'b0; law_q <= 1'b0;
      dout <= 1'b0; dout_oe <= 1'b0; rx_byte <= '0; rx_valid <= 1'b0;
    end else begin
      bclk_p <= {bclk_p[PW-2:0], bclk};
      strb_p <= {strb_p[PW-2:0], strb};
      din_p  <= {din_p[PW-2:0], din};
      rx_valid <= 1'b0;
      if (s_rise) begin
        tx_sh     <= tx_mute ? quiet_now : tx_byte;
        rx_mute_q <= rx_mute;
        law_q     <= law_a;
        txcnt     <= '0;
        rxcnt     <= '0;
        dout_oe   <= 1'b0;
      end else if (s_fall) begin
        dout_oe <= 1'b0;
      end else begin
        if (tx_step) begin
          dout    <= tx_sh[BITS-1];
          tx_sh   <= {tx_sh[BITS-2:0], 1'b0};
          txcnt   <= txcnt + 1'b1;
          dout_oe <= 1'b1;
        end
        if (rx_step) begin
          rx_sh <= {rx_sh[BITS-2:0], din_s};
          rxcnt <= rxcnt + 1'b1;
        end
        if (rx_last) begin
          dout_oe  <= 1'b0;
          rx_valid <= 1'b1;
          rx_byte  <= rx_mute_q ? quiet_q : {rx_sh[BITS-2:0], din_s};
        end
      end
    end
  end

  always_comb begin
    assert (rxcnt <= txcnt && txcnt <= CW'(BITS)); // R4
  end

  AST_OE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_p[SYNC-1] && !strb_p[SYNC]) |-> !dout_oe); // R2
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R4
  AST_NO_EXTRA_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (rxcnt == CW'(BITS) && !s_rise) |=> !rx_valid); // R9
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (txcnt == CW'(BITS) && !s_rise) |=> $stable(dout)); // R9
  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_mute_q) |-> (rx_byte == 8'h55 || rx_byte == 8'h7F)); // R6
endmodule

// File: tb/sim_pcm_strobe_port.sv
module sim_pcm_strobe_port;
  logic clk = 1'b0, rst_n = 1'b0, bclk = 1'b0, strb = 1'b0, din = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic tx_mute = 1'b0, rx_mute = 1'b0, law_a = 1'b0;
  logic dout, dout_oe, rx_valid;
  logic [7:0] rx_byte;
  int n_chk = 0, n_fail = 0, vcount = 0, cyc = 0;
  logic [7:0] vlast = 8'h00;

  always #4 clk = ~clk;

  pcm_strobe_port u0 (.clk, .rst_n, .bclk, .strb, .din, .tx_byte, .tx_mute,
    .rx_mute, .law_a, .dout, .dout_oe, .rx_byte, .rx_valid);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rx_valid) begin vcount <= vcount + 1; vlast <= rx_byte; end
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one timeslot; at bit index chg the slot-start inputs are flipped
  task automatic slot(input logic [7:0] txb, input logic [7:0] rxb, input logic tm,
                      input logic rm, input logic la, input int nbits, input int chg,
                      output logic [7:0] sent, output logic [7:0] got, output int pulses);
    int v0;
    @(negedge clk);
    tx_byte = txb; tx_mute = tm; rx_mute = rm; law_a = la;
    waitc(2);
    chk("R2 idle before strobe", {7'd0, dout_oe}, 8'h00);
    v0 = vcount;
    strb = 1'b1;
    waitc(8);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 8) ? rxb[7-i] : 1'b0;
      bclk = 1'b1;
      waitc(6);
      if (i < 8) begin
        sent[7-i] = dout;
        if (i == 0 || i == 7) chk("R2 drive in slot", {7'd0, dout_oe}, 8'h01);
      end else begin
        chk("R9 no drive after eighth", {7'd0, dout_oe}, 8'h00);
      end
      if (i == chg) begin
        tx_byte = ~tx_byte; tx_mute = ~tx_mute; rx_mute = ~rx_mute; law_a = ~law_a;
      end
      waitc(2);
      bclk = 1'b0;
      waitc(8);
    end
    got = vlast;
    pulses = vcount - v0;
    strb = 1'b0;
    waitc(8);
    chk("R2 released after slot", {7'd0, dout_oe}, 8'h00);
    tx_mute = 1'b0; rx_mute = 1'b0;
  endtask

  task automatic t_reset;
    waitc(3);
    chk("R1 oe in reset", {7'd0, dout_oe}, 8'h00);
    rst_n = 1'b1;
    waitc(4);
    chk("R1 oe idle", {7'd0, dout_oe}, 8'h00);
    chk("R1 valid idle", {7'd0, rx_valid}, 8'h00);
    chk("R1 rx_byte idle", rx_byte, 8'h00);
  endtask

  task automatic t_plain(input logic [7:0] txb, input logic [7:0] rxb);
    logic [7:0] s, g; int p;
    slot(txb, rxb, 1'b0, 1'b0, 1'b0, 8, -1, s, g, p);
    chk("R3 sent MSB first", s, txb);
    chk("R4 received byte", g, rxb);
    chk("R4 one valid pulse", 8'(p), 8'd1);
    chk("R4 rx_byte port", rx_byte, rxb);
  endtask

  task automatic t_mute(input logic la);
    logic [7:0] s, g; int p;
    logic [7:0] q = la ? 8'h55 : 8'h7F;
    slot(8'hC3, 8'h18, 1'b1, 1'b1, la, 8, -1, s, g, p);
    chk(la ? "R5 R7 tx quiet A-law" : "R5 R7 tx quiet mu-law", s, q);
    chk(la ? "R6 R7 rx quiet A-law" : "R6 R7 rx quiet mu-law", g, q);
    chk("R6 one valid pulse", 8'(p), 8'd1);
  endtask

  task automatic t_midslot;
    logic [7:0] s, g; int p;
    slot(8'h96, 8'hE1, 1'b0, 1'b0, 1'b1, 8, 2, s, g, p);
    chk("R3 R8 tx unaffected by mid-slot change", s, 8'h96);
    chk("R8 rx unaffected by mid-slot mute", g, 8'hE1);
    slot(8'h0F, 8'h42, 1'b1, 1'b1, 1'b0, 8, 4, s, g, p);
    chk("R8 tx stays muted mu-law", s, 8'h7F);
    chk("R8 rx stays muted mu-law", g, 8'h7F);
  endtask

  task automatic t_extra;
    logic [7:0] s, g; int p;
    slot(8'h5A, 8'hB4, 1'b0, 1'b0, 1'b0, 11, -1, s, g, p);
    chk("R9 tx byte with extra clocks", s, 8'h5A);
    chk("R9 rx byte with extra clocks", g, 8'hB4);
    chk("R9 single valid pulse", 8'(p), 8'd1);
  endtask

  initial begin
    t_reset();
    t_plain(8'hA5, 8'h3C);
    t_plain(8'h80, 8'hFF);
    t_plain(8'h01, 8'h2A);
    t_mute(1'b0);
    t_mute(1'b1);
    t_midslot();
    t_extra();
    t_plain(8'hD5, 8'h00);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule